// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host writes a character into a one-deep holding register. As soon as the shifter is free, that character moves into the shifter. The host can therefore queue the next character while the current one is still going out. When a character is already waiting as a frame ends, the next frame follows with no idle time.

The frame shape is chosen by control inputs: 7 or 8 data bits, an optional parity bit of selectable polarity, and one or two stop bits. The block steps through each bit on a rate enable that pulses 16 times per bit period. That enable comes from an external rate divider.

Two status flags are provided: holding register empty, and shifter done. A select input picks one of them as the interrupt source. The interrupt output pulses for one cycle whenever the selected flag goes from 0 to 1.

Top module: `uart_tx_dbuf`

## Requirements
- R1: Directly after reset, `txd` is 1, `buf_empty` is 1, `shift_done` is 1 and `irq` is 0.
- R2: A frame starts with one low start bit. The data follows least significant bit first. There are 8 data bits when `cfg_len8` is 1 and 7 data bits (bits 6..0) when it is 0. Every bit lasts exactly 16 cycles in which `tick16` is high.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. It is the XOR of the active data bits, inverted when `cfg_par_odd` is 1. When `cfg_par_en` is 0, no parity bit is sent.
- R4: The frame ends with one high stop bit when `cfg_stop2` is 0, and with two high stop bits when it is 1.
- R5: A write makes `buf_empty` 0 from the next cycle on. `buf_empty` returns to 1 in the cycle the character moves into the shifter, which happens one cycle after the write when the shifter is idle and enabled.
- R6: If a character is waiting when the last stop bit ends, its start bit begins immediately after that stop bit, with no gap.
- R7: `shift_done` is 0 while a frame is being sent. It becomes 1 at the start of the final stop bit (the second stop bit in two-stop mode) when no character is waiting, and it stays 1 while the shifter is idle.
- R8: `irq` pulses high for exactly one cycle on each 0-to-1 change of `buf_empty` when `cfg_irq_src` is 0, and of `shift_done` when `cfg_irq_src` is 1.
- R9: While `en` is 0, any frame in progress is abandoned, `txd` stays 1 and nothing leaves the holding register. A character written meanwhile stays queued and is sent once `en` returns to 1.
- R10: A write while a character is already waiting replaces that character. Only the newest one is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Transmitter enable |
| tick16 | input | 1 | Rate enable, 16 pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to queue |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_irq_src | input | 1 | 0 = interrupt on buffer empty, 1 = on shift done |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register empty |
| shift_done | output | 1 | Shifter idle or in its final stop bit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong bit counter or a wrong state shows on `txd` within one bit period. It appears as a misplaced level at the middle of some bit, or as a start edge that comes too early or too late after the stop bits. A lost or stuck queue state shows as `buf_empty` failing to drop in the cycle after a write, or failing to return one cycle later, or as a frame that never starts or repeats. Flag-edge mistakes appear as missing, doubled or widened `irq` pulses, counted over a complete frame or across a pair of back-to-back frames.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_irq_src,
  output logic       txd,
  output logic       buf_empty,
  output logic       shift_done,
  output logic       irq
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [7:0]    hold, sh;
  logic          full;
  logic [2:0]    bitn;
  logic [CW-1:0] tcnt;
  logic          len8_l, par_en_l, stop2_l, par_l;
  logic          tbe_q, tsc_q;

  wire       bit_end   = tick16 && (tcnt == CW'(OVS - 1));
  wire       last_stop = (st == S_STOP2) || (st == S_STOP1 && !stop2_l);
  wire       frame_end = last_stop && bit_end;
  wire       load      = en && full && (st == S_IDLE || frame_end);
  wire [7:0] mask      = cfg_len8 ? 8'hFF : 8'h7F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hold     <= '0;
      sh       <= '0;
      full     <= 1'b0;
      bitn     <= '0;
      tcnt     <= '0;
      len8_l   <= 1'b1;
      par_en_l <= 1'b0;
      stop2_l  <= 1'b0;
      par_l    <= 1'b0;
      tbe_q    <= 1'b1;
      tsc_q    <= 1'b1;
    end else begin
      tbe_q <= buf_empty;
      tsc_q <= shift_done;

      if (wr_en) begin
        hold <= wr_data;
        full <= 1'b1;
      end else if (load) begin
        full <= 1'b0;
      end

      if (!en) begin
        st   <= S_IDLE;
        tcnt <= '0;
      end else if (load) begin
        st       <= S_START;
        tcnt     <= '0;
        bitn     <= '0;
        sh       <= hold & mask;
        len8_l   <= cfg_len8;
        par_en_l <= cfg_par_en;
        stop2_l  <= cfg_stop2;
        par_l    <= (^(hold & mask)) ^ cfg_par_odd;
      end else if (st != S_IDLE && tick16) begin
        tcnt <= bit_end ? '0 : tcnt + 1'b1;
        if (bit_end) begin
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              sh   <= sh >> 1;
              bitn <= bitn + 3'd1;
              if (bitn == (len8_l ? 3'd7 : 3'd6))
                st <= par_en_l ? S_PAR : S_STOP1;
            end
            S_PAR:   st <= S_STOP1;
            S_STOP1: st <= stop2_l ? S_STOP2 : S_IDLE;
            S_STOP2: st <= S_IDLE;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = par_l;
      default: txd = 1'b1;
    endcase
  end

  assign buf_empty  = !full;
  assign shift_done = (st == S_IDLE) || (last_stop && !full);
  assign irq        = cfg_irq_src ? (shift_done && !tsc_q) : (buf_empty && !tbe_q);
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_en,
  input logic cfg_irq_src,
  input logic txd,
  input logic buf_empty,
  input logic shift_done,
  input logic irq
);
  assert_off_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd);

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);

  assert_empty_rise_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !shift_done);

  assert_done_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> txd);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_irq_src ? shift_done : buf_empty));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $stable(cfg_irq_src)) |-> !$past(irq));
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .cfg_irq_src(cfg_irq_src),
  .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .irq(irq)
);

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_irq_src = 1'b0;
  logic slow = 1'b0;
  logic [1:0] tdiv = '0;
  logic tick16, txd, buf_empty, shift_done, irq;
  int checks = 0, errors = 0, irq_cnt = 0, irq_wide = 0;
  logic irq_prev = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  assign tick16 = slow ? (tdiv == 2'd0) : 1'b1;

  always @(negedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (irq && irq_prev) irq_wide <= irq_wide + 1;
    irq_prev <= irq;
  end

  uart_tx_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_irq_src(cfg_irq_src),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cap(input bit skip, input bit l8, input bit pe, input bit s2,
                     output logic [7:0] d, output logic p, output logic st0,
                     output logic sp1, output logic sp2, output logic tscd,
                     output logic tsc1, output logic tsc2, output bit ok);
    int n;
    ok = 1'b1; d = '0; p = 1'b0; sp2 = 1'b1; tsc2 = 1'b1; tscd = 1'b0;
    if (!skip) begin
      n = 0;
      do begin @(negedge clk); n++; end while (txd !== 1'b0 && n < 3000);
      if (txd !== 1'b0) ok = 1'b0;
    end
    repeat (8) @(negedge clk);
    st0 = txd;
    for (int i = 0; i < (l8 ? 8 : 7); i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
      if (i == 0) tscd = shift_done;
    end
    if (pe) begin repeat (16) @(negedge clk); p = txd; end
    repeat (16) @(negedge clk);
    sp1 = txd; tsc1 = shift_done;
    if (s2) begin repeat (16) @(negedge clk); sp2 = txd; tsc2 = shift_done; end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(buf_empty === 1'b1, "R1 buf_empty", int'(buf_empty), 1);
    chk(shift_done === 1'b1, "R1 shift_done", int'(shift_done), 1);
    chk(irq === 1'b0, "R1 irq", int'(irq), 0);
  endtask

  task automatic t_frame(input bit l8, input bit pe, input bit odd, input bit s2, input logic [7:0] b);
    logic [7:0] d, m; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok;
    cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = odd; cfg_stop2 = s2;
    m = l8 ? 8'hFF : 8'h7F;
    wr(b);
    cap(1'b0, l8, pe, s2, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    chk(ok, "R2 frame start seen", int'(ok), 1);
    chk(st0 === 1'b0, "R2 start bit", int'(st0), 0);
    chk(d === (b & m), "R2 data bits", int'(d), int'(b & m));
    if (pe) chk(p === ((^(b & m)) ^ odd), "R3 parity", int'(p), int'((^(b & m)) ^ odd));
    chk(sp1 === 1'b1, "R4 stop bit 1", int'(sp1), 1);
    chk(tscd === 1'b0, "R7 busy during data", int'(tscd), 0);
    if (s2) begin
      chk(sp2 === 1'b1, "R4 stop bit 2", int'(sp2), 1);
      chk(tsc1 === 1'b0, "R7 not done at first of two stops", int'(tsc1), 0);
      chk(tsc2 === 1'b1, "R7 done at second stop", int'(tsc2), 1);
    end else begin
      chk(tsc1 === 1'b1, "R7 done at single stop", int'(tsc1), 1);
    end
    repeat (20) @(negedge clk);
    if (!pe) chk(txd === 1'b1, "R3 R4 no extra bit after frame", int'(txd), 1);
  endtask

  task automatic t_tbe_timing;
    cfg_len8 = 1; cfg_par_en = 0; cfg_stop2 = 0;
    wr(8'h0F);
    chk(buf_empty === 1'b0, "R5 empty drops after write", int'(buf_empty), 0);
    @(negedge clk);
    chk(buf_empty === 1'b1, "R5 empty returns at transfer", int'(buf_empty), 1);
    chk(txd === 1'b0, "R5 start bit at transfer", int'(txd), 0);
    repeat (200) @(negedge clk);
  endtask

  task automatic t_back2back;
    logic [7:0] d; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok; int g, base;
    cfg_len8 = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1; cfg_irq_src = 1;
    @(negedge clk); base = irq_cnt;
    wr(8'hA6);
    fork
      cap(1'b0, 1'b1, 1'b1, 1'b1, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
      begin repeat (30) @(negedge clk); wr(8'h39); end
    join
    chk(d === 8'hA6, "R6 first frame data", int'(d), 'hA6);
    chk(tsc2 === 1'b0, "R7 not done with byte queued", int'(tsc2), 0);
    g = 0;
    do begin @(negedge clk); g++; end while (txd !== 1'b0 && g < 40);
    chk(g == 8, "R6 no gap before next start", g, 8);
    cap(1'b1, 1'b1, 1'b1, 1'b1, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    chk(d === 8'h39, "R6 second frame data", int'(d), 'h39);
    chk(p === 1'b0, "R3 even parity of 39", int'(p), 0);
    repeat (20) @(negedge clk);
    chk(irq_cnt - base == 1, "R8 one done pulse for two frames", irq_cnt - base, 1);
  endtask

  task automatic t_irq_tbe;
    logic [7:0] d; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok; int base, wbase;
    cfg_irq_src = 0; cfg_len8 = 1; cfg_par_en = 0; cfg_stop2 = 0;
    @(negedge clk); base = irq_cnt; wbase = irq_wide;
    wr(8'h33);
    cap(1'b0, 1'b1, 1'b0, 1'b0, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    repeat (20) @(negedge clk);
    chk(irq_cnt - base == 1, "R8 one empty pulse", irq_cnt - base, 1);
    chk(irq_wide == wbase, "R8 pulse one cycle", irq_wide - wbase, 0);
  endtask

  task automatic t_irq_tsc;
    logic [7:0] d; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok; int base, mid;
    cfg_irq_src = 1; cfg_len8 = 0; cfg_par_en = 0; cfg_stop2 = 1;
    @(negedge clk); base = irq_cnt;
    wr(8'h5A);
    cap(1'b0, 1'b0, 1'b0, 1'b1, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    mid = irq_cnt - base;
    chk(mid == 1, "R8 done pulse by second stop", mid, 1);
    chk(d === 8'h5A, "R2 seven-bit data", int'(d), 'h5A);
    repeat (40) @(negedge clk);
    chk(irq_cnt - base == 1, "R8 no further done pulse", irq_cnt - base, 1);
    cfg_irq_src = 0;
  endtask

  task automatic t_disable;
    logic [7:0] d; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok; bit hi;
    cfg_len8 = 1; cfg_par_en = 0; cfg_stop2 = 0;
    wr(8'h00);
    repeat (40) @(negedge clk);
    en = 1'b0;
    hi = 1'b1;
    wr(8'h3C);
    repeat (40) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi, "R9 line high while disabled", int'(hi), 1);
    chk(buf_empty === 1'b0, "R9 queued byte held", int'(buf_empty), 0);
    @(negedge clk); en = 1'b1;
    cap(1'b0, 1'b1, 1'b0, 1'b0, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    chk(d === 8'h3C, "R9 queued byte sent after enable", int'(d), 'h3C);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_overwrite;
    logic [7:0] d; logic p, st0, sp1, sp2, tscd, tsc1, tsc2; bit ok; bit hi;
    en = 1'b0;
    wr(8'h11);
    wr(8'h22);
    @(negedge clk); en = 1'b1;
    cap(1'b0, 1'b1, 1'b0, 1'b0, d, p, st0, sp1, sp2, tscd, tsc1, tsc2, ok);
    chk(d === 8'h22, "R10 newest byte sent", int'(d), 'h22);
    hi = 1'b1;
    repeat (200) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi, "R10 older byte not sent", int'(hi), 1);
  endtask

  task automatic t_slow_tick;
    int n;
    slow = 1'b1; cfg_len8 = 1; cfg_par_en = 0; cfg_stop2 = 0;
    wr(8'h55);
    n = 0;
    do begin @(negedge clk); n++; end while (txd !== 1'b0 && n < 3000);
    do @(negedge clk); while (txd !== 1'b1);
    n = 0;
    while (txd === 1'b1 && n < 200) begin n++; @(negedge clk); end
    chk(n == 48, "R2 bit spans 16 ticks", n, 48);
    repeat (600) @(negedge clk);
    slow = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(1'b1, 1'b1, 1'b0, 1'b0, 8'hB3);
    t_frame(1'b0, 1'b1, 1'b1, 1'b1, 8'hC5);
    t_frame(1'b1, 1'b0, 1'b0, 1'b1, 8'h5A);
    t_frame(1'b0, 1'b0, 1'b0, 1'b0, 8'h7F);
    t_frame(1'b1, 1'b1, 1'b1, 1'b0, 8'h81);
    t_tbe_timing();
    t_back2back();
    t_irq_tsc();
    t_irq_tbe();
    t_disable();
    t_overwrite();
    t_slow_tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule